// File: doc/BRIEF.md
# Root Port Status and Change Register

This block holds the status-and-control word of a single downstream port of a root hub. Software sees one 32-bit word that it reads at any time and writes with a single-cycle strobe. On the hardware side the block follows the live connect, over-current, link-state and negotiated-speed inputs of the port's physical layer. It turns events on them into sticky change flags that software acknowledges by writing ones. It also runs the hot and warm port-reset handshakes and issues link-state change requests and wake requests.

A multi-port root hub instantiates one copy per port. Status fields update on the clock edge that samples the hardware inputs. A reset or link request leaves the block as a level or pulse one edge after the software write that caused it. Software writes always carry the full word, so read/write fields are rewritten by every write.

Top module: `port_status_ctl`

## Requirements
- R1: After reset every readable bit is 0, except bit 30, which follows `hw_removable`, and all request outputs are low.
- R2: Bit 0 mirrors the registered connect input and bit 3 the registered over-current input; any change of either sets bit 17 (connect change) or bit 20 (over-current change) respectively, on the same edge.
- R3: Change flags in bits 17..23 are sticky and are cleared only by writing 1 to them; writing 0 leaves them unchanged; when a set event and a clear hit the same edge, the flag stays set.
- R4: Writing 1 to bit 4 while the port is connected and no reset is running starts a hot reset: bit 4 reads 1 and `port_reset_req` is high until `hw_reset_done`; completion clears bit 4, sets bit 21 and sets the enabled bit 1.
- R5: Completion of a reset loads bits 13:10 with the speed input (0 undefined, 1 full, 2 low, 3 high, 4 super); a reserved speed code 5..15 loads 0; a disconnect clears the field to 0.
- R6: Writing 1 to bit 31 starts a warm reset: bits 31 and 4 read 1 and `warm_reset_req` is high; completion clears both, and sets bit 19 and bit 21.
- R7: A disconnect clears bit 1, sets bit 18 if the port was enabled, and ends any running reset, dropping the reset request and setting bit 21.
- R8: A write with bit 16 set raises `link_chg_req` for exactly one cycle, one edge later, with `link_chg_state` equal to written bits 8:5; a write without bit 16 raises no request; bit 16 reads 0.
- R9: Bits 8:5 track `hw_link_state` whenever `hw_link_valid` is high (U0=0, U1=1, U2=2, U3=3, Disabled=4, Inactive=6, Resume=15); bit 22 sets on U3->Resume, Resume->U0, U3->U0, U2->U0, U0->Disabled, and on entry to Inactive from any other state, and on no other transition.
- R10: Bit 9 (power) is read/write; bits 15:14 (indicator: 0 off, 1 amber, 2 green) take the written value, except that the code 3 is ignored and the previous value kept.
- R11: Bits 25, 26 and 27 enable wake on connect, disconnect and over-current onset; an enabled event raises `wake_req` for one cycle on the edge that records the event; a disabled one raises nothing.
- R12: Bits 2, 24, 28 and 29 read 0; bit 30 reads `hw_removable`; a `hw_cfg_err` pulse sets bit 23.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| sw_wr | input | 1 | Software write strobe, one cycle per write |
| sw_wdata | input | 32 | Software write data |
| sw_rdata | output | 32 | Current register word |
| hw_connect | input | 1 | Device-present level from the port |
| hw_overcurrent | input | 1 | Over-current level from the port |
| hw_link_state | input | 4 | Current link state code |
| hw_link_valid | input | 1 | Qualifies `hw_link_state` |
| hw_speed | input | 4 | Negotiated speed code, read at reset completion |
| hw_reset_done | input | 1 | Port signals end of hot or warm reset |
| hw_cfg_err | input | 1 | Pulse: link partner configuration failed |
| hw_removable | input | 1 | Device reported as removable |
| port_reset_req | output | 1 | Hot reset in progress |
| warm_reset_req | output | 1 | Warm reset in progress |
| link_chg_req | output | 1 | One-cycle link-state change request |
| link_chg_state | output | 4 | Target link state for the request |
| wake_req | output | 1 | One-cycle wake request to power management |

## Verification
A wrong internal state shows at the read word on the very next sample after the edge that records it. A lost or spurious change flag appears in bits 17..23 and persists until cleared, so even a one-cycle glitch in event detection stays visible. A reset controller stuck in the wrong state shows as a request output held high or a bit 4 that never falls, and the missing bit 21 or bit 19 exposes it one edge after the completion input. Link and wake decoding errors show as a pulse on `link_chg_req` or `wake_req` that is missing, doubled or misplaced by one cycle.

// File: rtl/port_sc_pkg.sv
// Package: shared bit positions, code values and state types for the
// port status register. Assumes a 32-bit register word.
package port_sc_pkg;

    localparam int WORD_W   = 32;
    localparam int LINK_W   = 4;
    localparam int SPEED_W  = 4;
    localparam int NUM_CHG  = 7;

    // Bit positions that software and neighbours decode
    localparam int B_CONN    = 0;
    localparam int B_EN      = 1;
    localparam int B_OC      = 3;
    localparam int B_RST     = 4;
    localparam int B_LINK_LO = 5;
    localparam int B_PWR     = 9;
    localparam int B_SPD_LO  = 10;
    localparam int B_IND_LO  = 14;
    localparam int B_STROBE  = 16;
    localparam int B_CHG_LO  = 17;
    localparam int B_WK_CON  = 25;
    localparam int B_WK_DIS  = 26;
    localparam int B_WK_OC   = 27;
    localparam int B_REMOV   = 30;
    localparam int B_WARM    = 31;

    // Index of each change flag inside the change bank (bit = B_CHG_LO + idx)
    localparam int C_CONN  = 0;
    localparam int C_EN    = 1;
    localparam int C_WARM  = 2;
    localparam int C_OC    = 3;
    localparam int C_RST   = 4;
    localparam int C_LINK  = 5;
    localparam int C_CFG   = 6;

    // Link state codes
    localparam logic [LINK_W-1:0] LS_U0       = 4'd0;
    localparam logic [LINK_W-1:0] LS_U2       = 4'd2;
    localparam logic [LINK_W-1:0] LS_U3       = 4'd3;
    localparam logic [LINK_W-1:0] LS_DISABLED = 4'd4;
    localparam logic [LINK_W-1:0] LS_INACTIVE = 4'd6;
    localparam logic [LINK_W-1:0] LS_RESUME   = 4'd15;

    // Highest speed code that is not reserved
    localparam logic [SPEED_W-1:0] SPD_MAX = 4'd4;

    // Indicator code that is reserved and ignored on write
    localparam logic [1:0] IND_RSVD = 2'd3;

    typedef enum logic [1:0] {
        RST_IDLE = 2'd0,
        RST_HOT  = 2'd1,
        RST_WARM = 2'd2
    } rst_state_t;

endpackage

// File: rtl/psc_change_bank.sv
// Sticky change-flag bank. Each flag sets on its event input and clears
// only on a clear request; a set on the same edge as a clear wins.
// Assumes set and clear inputs are single-cycle qualified requests.
module psc_change_bank #(
    parameter int N = 7
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [N-1:0] set_i,
    input  logic [N-1:0] clr_i,
    output logic [N-1:0] flags_o
);

    for (genvar i = 0; i < N; i++) begin : g_flag
        logic flag_q;

        // Hold one sticky flag: set has priority over clear
        always_ff @(posedge clk) begin
            if (!rst_n)
                flag_q <= 1'b0;
            else if (set_i[i])
                flag_q <= 1'b1;
            else if (clr_i[i])
                flag_q <= 1'b0;
        end

        assign flags_o[i] = flag_q;
    end

endmodule

// File: rtl/psc_reset_ctl.sv
// Port reset handshake. Runs one hot or warm reset at a time; a warm
// start wins over a hot start in the same write. The reset ends on the
// completion input or is abandoned on disconnect. Assumes the completion
// input is only meaningful while a reset runs.
module psc_reset_ctl
    import port_sc_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic start_hot_i,
    input  logic start_warm_i,
    input  logic done_i,
    input  logic abort_i,
    output logic busy_o,
    output logic hot_req_o,
    output logic warm_req_o,
    output logic fall_o,
    output logic ok_o,
    output logic warm_ok_o
);

    rst_state_t state_q, state_d;
    logic       leave;

    // Decide the next reset state
    always_comb begin
        state_d = state_q;
        leave   = 1'b0;
        unique case (state_q)
            RST_IDLE: begin
                if (start_warm_i)
                    state_d = RST_WARM;
                else if (start_hot_i)
                    state_d = RST_HOT;
            end
            RST_HOT, RST_WARM: begin
                if (abort_i || done_i) begin
                    state_d = RST_IDLE;
                    leave   = 1'b1;
                end
            end
            default: state_d = RST_IDLE;
        endcase
    end

    // Hold the reset state
    always_ff @(posedge clk) begin
        if (!rst_n)
            state_q <= RST_IDLE;
        else
            state_q <= state_d;
    end

    assign busy_o     = (state_q != RST_IDLE);
    assign hot_req_o  = (state_q == RST_HOT);
    assign warm_req_o = (state_q == RST_WARM);
    assign fall_o     = leave;
    assign ok_o       = leave && !abort_i;
    assign warm_ok_o  = leave && !abort_i && (state_q == RST_WARM);

endmodule

// File: rtl/psc_link_watch.sv
// Link state tracker. Captures the qualified link state and flags the
// transitions that software must be told about. Assumes the state input
// is stable while its valid strobe is high.
module psc_link_watch
    import port_sc_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              valid_i,
    input  logic [LINK_W-1:0] state_i,
    output logic [LINK_W-1:0] state_o,
    output logic              notify_o
);

    logic [LINK_W-1:0] cur_q;
    logic              hit;

    // Classify the transition from the held state to the new one
    always_comb begin
        hit = 1'b0;
        if (valid_i) begin
            if (cur_q == LS_U3 && state_i == LS_RESUME)          hit = 1'b1;
            if (cur_q == LS_RESUME && state_i == LS_U0)          hit = 1'b1;
            if (cur_q == LS_U3 && state_i == LS_U0)              hit = 1'b1;
            if (cur_q == LS_U2 && state_i == LS_U0)              hit = 1'b1;
            if (cur_q == LS_U0 && state_i == LS_DISABLED)        hit = 1'b1;
            if (cur_q != LS_INACTIVE && state_i == LS_INACTIVE)  hit = 1'b1;
        end
    end

    // Capture the qualified link state
    always_ff @(posedge clk) begin
        if (!rst_n)
            cur_q <= LS_U0;
        else if (valid_i)
            cur_q <= state_i;
    end

    assign state_o  = cur_q;
    assign notify_o = hit;

endmodule

// File: rtl/port_status_ctl.sv
// One root-hub port status-and-control register. Combines live status,
// sticky change flags, reset handshake, link watch, link-change requests
// and wake requests. Assumes full-word software writes and hardware
// inputs already synchronous to clk.
module port_status_ctl
    import port_sc_pkg::*;
(
    input  logic                clk,
    input  logic                rst_n,
    input  logic                sw_wr,
    input  logic [WORD_W-1:0]   sw_wdata,
    output logic [WORD_W-1:0]   sw_rdata,
    input  logic                hw_connect,
    input  logic                hw_overcurrent,
    input  logic [LINK_W-1:0]   hw_link_state,
    input  logic                hw_link_valid,
    input  logic [SPEED_W-1:0]  hw_speed,
    input  logic                hw_reset_done,
    input  logic                hw_cfg_err,
    input  logic                hw_removable,
    output logic                port_reset_req,
    output logic                warm_reset_req,
    output logic                link_chg_req,
    output logic [LINK_W-1:0]   link_chg_state,
    output logic                wake_req
);

    localparam int CHG_HI = B_CHG_LO + NUM_CHG - 1;

    logic                conn_q, oc_q, en_q, pwr_q;
    logic [SPEED_W-1:0]  speed_q;
    logic [1:0]          ind_q;
    logic [2:0]          wake_en_q;
    logic                lreq_q, wake_q;
    logic [LINK_W-1:0]   lstate_q;

    logic                conn_rise, conn_fall, oc_rise, oc_chg;
    logic                rst_busy, rst_fall, rst_ok, warm_ok;
    logic                hot_req, warm_req;
    logic                start_hot, start_warm;
    logic [LINK_W-1:0]   link_cur;
    logic                link_note;
    logic [NUM_CHG-1:0]  chg_set, chg_clr, chg_flags;
    logic [SPEED_W-1:0]  speed_load;
    logic                unused_wdata;

    // Edge detection of the hardware level inputs
    assign conn_rise = !conn_q && hw_connect;
    assign conn_fall = conn_q && !hw_connect;
    assign oc_rise   = !oc_q && hw_overcurrent;
    assign oc_chg    = oc_q != hw_overcurrent;

    // Reset starts from software
    assign start_hot  = sw_wr && sw_wdata[B_RST] && conn_q && hw_connect;
    assign start_warm = sw_wr && sw_wdata[B_WARM];

    psc_reset_ctl u_rst (
        .clk          (clk),
        .rst_n        (rst_n),
        .start_hot_i  (start_hot),
        .start_warm_i (start_warm),
        .done_i       (hw_reset_done),
        .abort_i      (conn_fall),
        .busy_o       (rst_busy),
        .hot_req_o    (hot_req),
        .warm_req_o   (warm_req),
        .fall_o       (rst_fall),
        .ok_o         (rst_ok),
        .warm_ok_o    (warm_ok)
    );

    psc_link_watch u_link (
        .clk      (clk),
        .rst_n    (rst_n),
        .valid_i  (hw_link_valid),
        .state_i  (hw_link_state),
        .state_o  (link_cur),
        .notify_o (link_note)
    );

    // Gather change events into the sticky bank
    always_comb begin
        chg_set         = '0;
        chg_set[C_CONN] = conn_rise || conn_fall;
        chg_set[C_EN]   = conn_fall && en_q;
        chg_set[C_WARM] = warm_ok;
        chg_set[C_OC]   = oc_chg;
        chg_set[C_RST]  = rst_fall;
        chg_set[C_LINK] = link_note;
        chg_set[C_CFG]  = hw_cfg_err;
        chg_clr         = sw_wr ? sw_wdata[CHG_HI:B_CHG_LO] : '0;
    end

    psc_change_bank #(.N(NUM_CHG)) u_chg (
        .clk     (clk),
        .rst_n   (rst_n),
        .set_i   (chg_set),
        .clr_i   (chg_clr),
        .flags_o (chg_flags)
    );

    // Reserved speed codes load as undefined
    assign speed_load = (hw_speed > SPD_MAX) ? '0 : hw_speed;

    // Live status: connect, over-current, enable and speed
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            conn_q  <= 1'b0;
            oc_q    <= 1'b0;
            en_q    <= 1'b0;
            speed_q <= '0;
        end else begin
            conn_q <= hw_connect;
            oc_q   <= hw_overcurrent;
            if (conn_fall) begin
                en_q    <= 1'b0;
                speed_q <= '0;
            end else if (rst_ok) begin
                en_q    <= 1'b1;
                speed_q <= speed_load;
            end
        end
    end

    // Software read/write fields: power, indicator, wake enables
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            pwr_q     <= 1'b0;
            ind_q     <= 2'd0;
            wake_en_q <= 3'd0;
        end else if (sw_wr) begin
            pwr_q     <= sw_wdata[B_PWR];
            wake_en_q <= sw_wdata[B_WK_OC:B_WK_CON];
            if (sw_wdata[B_IND_LO+1:B_IND_LO] != IND_RSVD)
                ind_q <= sw_wdata[B_IND_LO+1:B_IND_LO];
        end
    end

    // Link-state change request, issued only with the strobe
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            lreq_q   <= 1'b0;
            lstate_q <= '0;
        end else begin
            lreq_q <= sw_wr && sw_wdata[B_STROBE];
            if (sw_wr && sw_wdata[B_STROBE])
                lstate_q <= sw_wdata[B_LINK_LO+LINK_W-1:B_LINK_LO];
        end
    end

    // Wake request on an enabled wake event
    always_ff @(posedge clk) begin
        if (!rst_n)
            wake_q <= 1'b0;
        else
            wake_q <= (conn_rise && wake_en_q[0])
                   || (conn_fall && wake_en_q[1])
                   || (oc_rise   && wake_en_q[2]);
    end

    // Assemble the read word
    always_comb begin
        sw_rdata                                  = '0;
        sw_rdata[B_CONN]                          = conn_q;
        sw_rdata[B_EN]                            = en_q;
        sw_rdata[B_OC]                            = oc_q;
        sw_rdata[B_RST]                           = rst_busy;
        sw_rdata[B_LINK_LO+LINK_W-1:B_LINK_LO]    = link_cur;
        sw_rdata[B_PWR]                           = pwr_q;
        sw_rdata[B_SPD_LO+SPEED_W-1:B_SPD_LO]     = speed_q;
        sw_rdata[B_IND_LO+1:B_IND_LO]             = ind_q;
        sw_rdata[CHG_HI:B_CHG_LO]                 = chg_flags;
        sw_rdata[B_WK_OC:B_WK_CON]                = wake_en_q;
        sw_rdata[B_REMOV]                         = hw_removable;
        sw_rdata[B_WARM]                          = warm_req;
    end

    assign port_reset_req = hot_req;
    assign warm_reset_req = warm_req;
    assign link_chg_req   = lreq_q;
    assign link_chg_state = lstate_q;
    assign wake_req       = wake_q;

    // Write bits with no storage behind them
    assign unused_wdata = ^{sw_wdata[B_OC:B_CONN], sw_wdata[24],
                            sw_wdata[B_REMOV:28]};

endmodule

// File: rtl/psc_checks.sv
// Checker for port_status_ctl: temporal rules between software writes,
// hardware inputs and the read word. Attached by bind below.
module psc_checks
    import port_sc_pkg::*;
(
    input logic               clk,
    input logic               rst_n,
    input logic               sw_wr,
    input logic [WORD_W-1:0]  sw_wdata,
    input logic [WORD_W-1:0]  sw_rdata,
    input logic               hw_connect,
    input logic               port_reset_req,
    input logic               warm_reset_req,
    input logic               link_chg_req
);

    // R3: a set change flag survives any edge without a clearing write
    assert_flag_sticky_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (sw_rdata[B_CHG_LO] && !(sw_wr && sw_wdata[B_CHG_LO])) |=> sw_rdata[B_CHG_LO]);

    // R4: the reset bit never falls without the reset-change flag
    assert_reset_fall_R4: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(sw_rdata[B_RST]) |-> sw_rdata[B_CHG_LO + C_RST]);

    // R6: hot and warm reset requests are never raised together
    assert_one_reset_R6: assert property (@(posedge clk) disable iff (!rst_n)
        !(port_reset_req && warm_reset_req));

    // R7: disconnect of an enabled port clears enable and flags it
    assert_disc_disable_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (sw_rdata[B_CONN] && !hw_connect && sw_rdata[B_EN])
        |=> (!sw_rdata[B_EN] && sw_rdata[B_CHG_LO + C_EN]));

    // R8: a link request only follows a strobed write
    assert_link_strobe_R8: assert property (@(posedge clk) disable iff (!rst_n)
        !(sw_wr && sw_wdata[B_STROBE]) |=> !link_chg_req);

    // R12: reserved bits and the strobe bit read zero
    assert_reserved_zero_R12: assert property (@(posedge clk) disable iff (!rst_n)
        (sw_rdata[2] == 1'b0) && (sw_rdata[24] == 1'b0)
        && (sw_rdata[29:28] == 2'b00) && (sw_rdata[B_STROBE] == 1'b0));

endmodule

bind port_status_ctl psc_checks u_psc_checks (
    .clk            (clk),
    .rst_n          (rst_n),
    .sw_wr          (sw_wr),
    .sw_wdata       (sw_wdata),
    .sw_rdata       (sw_rdata),
    .hw_connect     (hw_connect),
    .port_reset_req (port_reset_req),
    .warm_reset_req (warm_reset_req),
    .link_chg_req   (link_chg_req)
);

// File: tb/port_status_ctl_test.sv
module port_status_ctl_test;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        sw_wr = 1'b0;
    logic [31:0] sw_wdata = '0;
    logic [31:0] sw_rdata;
    logic        hw_connect = 1'b0;
    logic        hw_overcurrent = 1'b0;
    logic [3:0]  hw_link_state = '0;
    logic        hw_link_valid = 1'b0;
    logic [3:0]  hw_speed = '0;
    logic        hw_reset_done = 1'b0;
    logic        hw_cfg_err = 1'b0;
    logic        hw_removable = 1'b0;
    logic        port_reset_req, warm_reset_req, link_chg_req, wake_req;
    logic [3:0]  link_chg_state;

    int checks = 0;
    int errors = 0;

    always #2.5 clk = ~clk;

    port_status_ctl uut (
        .clk(clk), .rst_n(rst_n), .sw_wr(sw_wr), .sw_wdata(sw_wdata),
        .sw_rdata(sw_rdata), .hw_connect(hw_connect),
        .hw_overcurrent(hw_overcurrent), .hw_link_state(hw_link_state),
        .hw_link_valid(hw_link_valid), .hw_speed(hw_speed),
        .hw_reset_done(hw_reset_done), .hw_cfg_err(hw_cfg_err),
        .hw_removable(hw_removable), .port_reset_req(port_reset_req),
        .warm_reset_req(warm_reset_req), .link_chg_req(link_chg_req),
        .link_chg_state(link_chg_state), .wake_req(wake_req)
    );

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual=%h expected=%h", req, act, exp);
        end
    endtask

    // Advance one clock; inputs change and outputs are sampled at negedge
    task automatic step();
        @(posedge clk);
        @(negedge clk);
    endtask

    task automatic wr(input logic [31:0] d);
        sw_wr = 1'b1; sw_wdata = d;
        step();
        sw_wr = 1'b0; sw_wdata = '0;
    endtask

    task automatic done_pulse();
        hw_reset_done = 1'b1;
        step();
        hw_reset_done = 1'b0;
    endtask

    task automatic t_reset_state();
        check("R1 word", sw_rdata, 32'h0);
        check("R1 outs", {28'd0, port_reset_req, warm_reset_req, link_chg_req, wake_req}, 32'h0);
        hw_removable = 1'b1; #1;
        check("R1 removable", {31'd0, sw_rdata[30]}, 32'd1);
        hw_removable = 1'b0; #1;
    endtask

    task automatic t_connect_oc();
        hw_connect = 1'b1; step();
        check("R2 connect", {30'd0, sw_rdata[17], sw_rdata[0]}, 32'd3);
        hw_overcurrent = 1'b1; step();
        check("R2 oc", {30'd0, sw_rdata[20], sw_rdata[3]}, 32'd3);
        wr(32'h0012_0000);
        check("R2 cleared", {30'd0, sw_rdata[20], sw_rdata[17]}, 32'd0);
        hw_overcurrent = 1'b0; step();
        check("R2 oc fall", {30'd0, sw_rdata[20], sw_rdata[3]}, 32'd2);
        wr(32'h0010_0000);
    endtask

    task automatic t_w1c();
        hw_cfg_err = 1'b1; step(); hw_cfg_err = 1'b0;
        check("R12 cfg err", {31'd0, sw_rdata[23]}, 32'd1);
        wr(32'h0);
        check("R3 zero write keeps", {31'd0, sw_rdata[23]}, 32'd1);
        sw_wr = 1'b1; sw_wdata = 32'h0080_0000; hw_cfg_err = 1'b1; step();
        sw_wr = 1'b0; sw_wdata = '0; hw_cfg_err = 1'b0;
        check("R3 set wins", {31'd0, sw_rdata[23]}, 32'd1);
        wr(32'h0080_0000);
        check("R3 one clears", {31'd0, sw_rdata[23]}, 32'd0);
    endtask

    task automatic t_port_reset(input logic [3:0] spd, input logic [3:0] exp_spd);
        hw_speed = spd;
        wr(32'h0000_0010);
        check("R4 busy", {30'd0, port_reset_req, sw_rdata[4]}, 32'd3);
        step();
        check("R4 holds", {31'd0, port_reset_req}, 32'd1);
        done_pulse();
        check("R4 done", {29'd0, port_reset_req, sw_rdata[4], sw_rdata[21]}, 32'd1);
        check("R4 enabled", {31'd0, sw_rdata[1]}, 32'd1);
        check("R5 speed", {28'd0, sw_rdata[13:10]}, {28'd0, exp_spd});
        wr(32'h0020_0000);
    endtask

    task automatic t_warm();
        wr(32'h8000_0000);
        check("R6 busy", {29'd0, warm_reset_req, sw_rdata[31], sw_rdata[4]}, 32'd7);
        check("R6 not hot", {31'd0, port_reset_req}, 32'd0);
        done_pulse();
        check("R6 done", {28'd0, warm_reset_req, sw_rdata[31], sw_rdata[19], sw_rdata[21]}, 32'd3);
        wr(32'h0028_0000);
    endtask

    task automatic t_disconnect();
        hw_connect = 1'b0; step();
        check("R7 disable", {29'd0, sw_rdata[1], sw_rdata[18], sw_rdata[17]}, 32'd3);
        check("R5 speed cleared", {28'd0, sw_rdata[13:10]}, 32'd0);
        wr(32'h0006_0000);
        hw_connect = 1'b1; step();
        wr(32'h0002_0010);
        check("R7 reset running", {31'd0, port_reset_req}, 32'd1);
        hw_connect = 1'b0; step();
        check("R7 abort", {29'd0, port_reset_req, sw_rdata[1], sw_rdata[21]}, 32'd1);
        check("R7 no enable change", {31'd0, sw_rdata[18]}, 32'd0);
        wr(32'h0022_0000);
    endtask

    task automatic t_link_write();
        wr(32'h0001_0060);
        check("R8 request", {27'd0, link_chg_req, link_chg_state}, 32'h13);
        check("R8 strobe reads 0", {31'd0, sw_rdata[16]}, 32'd0);
        step();
        check("R8 one cycle", {31'd0, link_chg_req}, 32'd0);
        wr(32'h0000_0060);
        check("R8 no strobe", {31'd0, link_chg_req}, 32'd0);
    endtask

    task automatic link_to(input logic [3:0] s);
        hw_link_state = s; hw_link_valid = 1'b1; step(); hw_link_valid = 1'b0;
    endtask

    task automatic expect_plc(input string tag, input logic [3:0] s, input logic exp);
        link_to(s);
        check({"R9 ", tag}, {27'd0, sw_rdata[22], sw_rdata[8:5]}, {27'd0, exp, s});
        wr(32'h0040_0000);
    endtask

    task automatic t_link_watch();
        expect_plc("U0 to U3", 4'd3, 1'b0);
        expect_plc("U3 to Resume", 4'd15, 1'b1);
        expect_plc("Resume to U0", 4'd0, 1'b1);
        expect_plc("U0 to U2", 4'd2, 1'b0);
        expect_plc("U2 to U0", 4'd0, 1'b1);
        expect_plc("U0 to U1", 4'd1, 1'b0);
        expect_plc("to Inactive", 4'd6, 1'b1);
        expect_plc("Inactive again", 4'd6, 1'b0);
        expect_plc("Inactive to U0", 4'd0, 1'b0);
        expect_plc("U0 to Disabled", 4'd4, 1'b1);
        expect_plc("Disabled to U3", 4'd3, 1'b0);
        expect_plc("U3 to U0", 4'd0, 1'b1);
        hw_link_state = 4'd2; step();
        check("R9 ignored without valid", {28'd0, sw_rdata[8:5]}, 32'd0);
    endtask

    task automatic t_indicator();
        wr(32'h0000_8200);
        check("R10 green power", {29'd0, sw_rdata[15:14], sw_rdata[9]}, 32'd5);
        wr(32'h0000_C200);
        check("R10 code 3 ignored", {30'd0, sw_rdata[15:14]}, 32'd2);
        wr(32'h0000_4000);
        check("R10 amber no power", {29'd0, sw_rdata[15:14], sw_rdata[9]}, 32'd2);
    endtask

    task automatic t_wake();
        wr(32'h0200_0000);
        hw_connect = 1'b1; step();
        check("R11 wake on connect", {31'd0, wake_req}, 32'd1);
        step();
        check("R11 one cycle", {31'd0, wake_req}, 32'd0);
        hw_connect = 1'b0; step();
        check("R11 disconnect disabled", {31'd0, wake_req}, 32'd0);
        wr(32'h0C02_0000);
        check("R11 enables read", {29'd0, sw_rdata[27:25]}, 32'd6);
        hw_overcurrent = 1'b1; step();
        check("R11 wake on oc", {31'd0, wake_req}, 32'd1);
        hw_overcurrent = 1'b0; step();
        check("R11 oc fall no wake", {31'd0, wake_req}, 32'd0);
        wr(32'h0012_0000);
    endtask

    task automatic t_reserved();
        wr(32'h3100_0004);
        check("R12 reserved zero", {28'd0, sw_rdata[29], sw_rdata[28], sw_rdata[24], sw_rdata[2]}, 32'd0);
        hw_removable = 1'b1; step();
        check("R12 removable", {31'd0, sw_rdata[30]}, 32'd1);
    endtask

    initial begin : watchdog
        repeat (20000) @(posedge clk);
        errors++;
        $display("FAIL watchdog: actual=timeout expected=finish");
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin : main
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset_state();
        t_connect_oc();
        t_w1c();
        t_port_reset(4'd3, 4'd3);
        t_port_reset(4'd9, 4'd0);
        t_port_reset(4'd4, 4'd4);
        t_warm();
        t_disconnect();
        t_link_write();
        t_link_watch();
        t_indicator();
        t_wake();
        t_reserved();
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

endmodule